// File: doc/BRIEF.md
# Cassette Tape Transport Interface

This block connects a host controller to a digital cassette drive. Host requests for play forward, play reverse, fast forward, fast reverse and stop are held as a command. The command is turned into three active-high motor lines: forward, reverse and fast. A hard interlock means forward and reverse are never driven together. A reversal always passes through a cycle with the motor off. The motor is also stopped when the cassette is removed, and when the clear leader comes under the sensor during motion.

The drive also supplies a read clock and a read data line. The bit rate of these lines rises as the tape plays. The block resynchronizes both lines and samples the data on each rising edge of the read clock. It never assumes a fixed bit period. Bits are assembled most significant first into bytes, and each finished byte is flagged with a one-cycle pulse. The synchronized cassette-sense and leader levels are also passed to the host as status.

Top module: `tape_xport`

## Requirements
- R1: `mot_fwd_o` and `mot_rev_o` are never high in the same cycle.
- R2: A single-cycle request that asks for a forward-type motion (play or fast) together with a reverse-type motion drops the held command, turns the motor off and sets `ilock_err_o`. The flag stays high until the next accepted motion request or stop request, which clears it.
- R3: Requests and their outputs {fwd, rev, fast}:
  - play forward gives 1,0,0
  - play reverse gives 0,1,0
  - fast forward gives 1,0,1
  - fast reverse gives 0,1,1
  - stop gives 0,0,0

  From rest, the outputs change on the first clock edge that samples the request. `mot_fast_o` is never high unless one of the direction outputs is high.
- R4: When the held direction reverses, both direction outputs are low for exactly one cycle before the new direction is driven.
- R5: While the synchronized cassette sense is low, all motor outputs are low and motion requests are ignored. The held command is dropped, so the motor does not restart when the cassette returns.
- R6: A rising edge of the synchronized leader input while a motion command is held stops the motor. A motion started while the leader is already present runs until the leader falls and rises again.
- R7: Each rising edge of the synchronized read clock shifts in the synchronized read data level (high = 1) at the least significant end. After eight such edges, `byte_o` takes the assembled byte (first bit in bit 7) and `byte_vld_o` pulses high for one cycle. This works for any clock period of at least two cycles high and two cycles low.
- R8: `cas_present_o` and `at_leader_o` follow the sense and leader inputs through a two-flop synchronizer.
- R9: After reset, all motor outputs, `ilock_err_o`, `byte_vld_o` and `byte_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_play_fwd | input | 1 | Request normal-speed forward motion |
| req_play_rev | input | 1 | Request normal-speed reverse motion |
| req_fast_fwd | input | 1 | Request fast forward |
| req_fast_rev | input | 1 | Request fast reverse |
| req_stop | input | 1 | Request stop; also clears the interlock flag |
| cas_sense_i | input | 1 | High when a cassette is in and the lid is shut (asynchronous) |
| leader_i | input | 1 | High when clear leader is under the sensor (asynchronous) |
| rd_clk_i | input | 1 | Drive read clock (asynchronous, rising rate) |
| rd_dat_i | input | 1 | Drive read data (asynchronous) |
| mot_fwd_o | output | 1 | Forward motor drive |
| mot_rev_o | output | 1 | Reverse motor drive |
| mot_fast_o | output | 1 | Fast-speed motor drive |
| cas_present_o | output | 1 | Synchronized cassette present |
| at_leader_o | output | 1 | Synchronized leader detected |
| ilock_err_o | output | 1 | Conflicting direction request seen |
| byte_o | output | 8 | Last assembled byte |
| byte_vld_o | output | 1 | One-cycle pulse when byte_o updates |

## Verification
The checker watches four things on every cycle:
- forward and reverse are never high together;
- fast never appears without a direction;
- a direction output never follows the opposite one in the next cycle;
- the motor is off whenever the cassette is absent or the interlock flag is up.

It also checks that the byte strobe never lasts two cycles. Only the bench scenarios can show the rest:
- the exact output code for each request;
- the stop at a leader edge, while a start already on the leader keeps running;
- that a dropped command stays dropped when the cassette comes back;
- the bit order and contents of bytes read at a steadily shrinking clock period.

// File: rtl/tape_xport_pkg.sv
package tape_xport_pkg;
    typedef enum logic [1:0] {
        DIR_OFF = 2'd0,
        DIR_FWD = 2'd1,
        DIR_REV = 2'd2
    } dir_e;
endpackage

// File: rtl/tx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous levels.
module tx_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/tx_motor.sv
// Command latch, interlock and motor output stage.
module tx_motor
    import tape_xport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_play_fwd,
    input  logic req_play_rev,
    input  logic req_fast_fwd,
    input  logic req_fast_rev,
    input  logic req_stop,
    input  logic sense_s,
    input  logic lead_s,
    output logic mot_fwd_o,
    output logic mot_rev_o,
    output logic mot_fast_o,
    output logic err_o
);
    typedef struct packed {
        dir_e cmd;
        logic cmd_fast;
        dir_e out;
        logic out_fast;
        logic err;
        logic lead_prev;
    } mst_t;

    mst_t st_d, st_q;
    logic any_f, any_r, lead_rise;

    always_comb begin
        any_f     = req_play_fwd | req_fast_fwd;
        any_r     = req_play_rev | req_fast_rev;
        lead_rise = lead_s & ~st_q.lead_prev;
        st_d      = st_q;
        st_d.lead_prev = lead_s;

        if (!sense_s) begin
            st_d.cmd      = DIR_OFF;
            st_d.cmd_fast = 1'b0;
        end else if (req_stop) begin
            st_d.cmd      = DIR_OFF;
            st_d.cmd_fast = 1'b0;
            st_d.err      = 1'b0;
        end else if (any_f && any_r) begin
            st_d.cmd      = DIR_OFF;
            st_d.cmd_fast = 1'b0;
            st_d.err      = 1'b1;
        end else if (any_f) begin
            st_d.cmd      = DIR_FWD;
            st_d.cmd_fast = req_fast_fwd;
            st_d.err      = 1'b0;
        end else if (any_r) begin
            st_d.cmd      = DIR_REV;
            st_d.cmd_fast = req_fast_rev;
            st_d.err      = 1'b0;
        end else if (st_q.cmd != DIR_OFF && lead_rise) begin
            st_d.cmd      = DIR_OFF;
            st_d.cmd_fast = 1'b0;
        end

        // Output stage: insert one idle cycle on a reversal.
        if (st_d.cmd == DIR_OFF) begin
            st_d.out = DIR_OFF;
        end else if (st_q.out != DIR_OFF && st_q.out != st_d.cmd) begin
            st_d.out = DIR_OFF;
        end else begin
            st_d.out = st_d.cmd;
        end
        st_d.out_fast = (st_d.out != DIR_OFF) && st_d.cmd_fast;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mot_fwd_o  = (st_q.out == DIR_FWD);
    assign mot_rev_o  = (st_q.out == DIR_REV);
    assign mot_fast_o = st_q.out_fast;
    assign err_o      = st_q.err;
endmodule

// File: rtl/tx_deser.sv
// Clock-qualified serial capture, MSB first.
module tx_deser #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ck_s,
    input  logic          dt_s,
    output logic [BW-1:0] byte_o,
    output logic          vld_o
);
    localparam int CW = (BW > 1) ? $clog2(BW) : 1;

    typedef struct packed {
        logic [BW-1:0] sh;
        logic [CW-1:0] cnt;
        logic [BW-1:0] data;
        logic          vld;
        logic          ck_prev;
    } dst_t;

    dst_t st_d, st_q;
    logic [BW-1:0] shifted;

    always_comb begin
        st_d         = st_q;
        st_d.vld     = 1'b0;
        st_d.ck_prev = ck_s;
        shifted      = {st_q.sh[BW-2:0], dt_s};
        if (ck_s && !st_q.ck_prev) begin
            st_d.sh = shifted;
            if (st_q.cnt == CW'(BW - 1)) begin
                st_d.cnt  = '0;
                st_d.data = shifted;
                st_d.vld  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o = st_q.data;
    assign vld_o  = st_q.vld;
endmodule

// File: rtl/tape_xport.sv
module tape_xport #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_play_fwd,
    input  logic              req_play_rev,
    input  logic              req_fast_fwd,
    input  logic              req_fast_rev,
    input  logic              req_stop,
    input  logic              cas_sense_i,
    input  logic              leader_i,
    input  logic              rd_clk_i,
    input  logic              rd_dat_i,
    output logic              mot_fwd_o,
    output logic              mot_rev_o,
    output logic              mot_fast_o,
    output logic              cas_present_o,
    output logic              at_leader_o,
    output logic              ilock_err_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] syn;

    tx_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({rd_dat_i, rd_clk_i, leader_i, cas_sense_i}),
        .sync_o  (syn)
    );

    tx_motor u_motor (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_play_fwd (req_play_fwd),
        .req_play_rev (req_play_rev),
        .req_fast_fwd (req_fast_fwd),
        .req_fast_rev (req_fast_rev),
        .req_stop     (req_stop),
        .sense_s      (syn[0]),
        .lead_s       (syn[1]),
        .mot_fwd_o    (mot_fwd_o),
        .mot_rev_o    (mot_rev_o),
        .mot_fast_o   (mot_fast_o),
        .err_o        (ilock_err_o)
    );

    tx_deser #(.BW(BYTE_W)) u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .ck_s   (syn[2]),
        .dt_s   (syn[3]),
        .byte_o (byte_o),
        .vld_o  (byte_vld_o)
    );

    assign cas_present_o = syn[0];
    assign at_leader_o   = syn[1];
endmodule

// File: rtl/tape_xport_chk.sv
module tape_xport_chk (
    input logic clk,
    input logic rst_n,
    input logic mot_fwd_o,
    input logic mot_rev_o,
    input logic mot_fast_o,
    input logic cas_present_o,
    input logic ilock_err_o,
    input logic byte_vld_o
);
    AST_NO_BOTH_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(mot_fwd_o && mot_rev_o)); // R1
    AST_ERR_MOTOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ilock_err_o |-> (!mot_fwd_o && !mot_rev_o)); // R2
    AST_FAST_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        mot_fast_o |-> (mot_fwd_o || mot_rev_o)); // R3
    AST_REV_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mot_rev_o |-> !$past(mot_fwd_o)); // R4
    AST_FWD_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mot_fwd_o |-> !$past(mot_rev_o)); // R4
    AST_NO_CASSETTE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_present_o |=> (!mot_fwd_o && !mot_rev_o && !mot_fast_o)); // R5
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o); // R7
endmodule

bind tape_xport tape_xport_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mot_fwd_o     (mot_fwd_o),
    .mot_rev_o     (mot_rev_o),
    .mot_fast_o    (mot_fast_o),
    .cas_present_o (cas_present_o),
    .ilock_err_o   (ilock_err_o),
    .byte_vld_o    (byte_vld_o)
);

// File: tb/tape_xport_tb.sv
module tape_xport_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_play_fwd = 0, req_play_rev = 0, req_fast_fwd = 0, req_fast_rev = 0, req_stop = 0;
    logic cas_sense_i = 0, leader_i = 0, rd_clk_i = 0, rd_dat_i = 0;
    logic mot_fwd_o, mot_rev_o, mot_fast_o, cas_present_o, at_leader_o, ilock_err_o;
    logic [7:0] byte_o;
    logic byte_vld_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_xport u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_play_fwd(req_play_fwd), .req_play_rev(req_play_rev),
        .req_fast_fwd(req_fast_fwd), .req_fast_rev(req_fast_rev), .req_stop(req_stop),
        .cas_sense_i(cas_sense_i), .leader_i(leader_i),
        .rd_clk_i(rd_clk_i), .rd_dat_i(rd_dat_i),
        .mot_fwd_o(mot_fwd_o), .mot_rev_o(mot_rev_o), .mot_fast_o(mot_fast_o),
        .cas_present_o(cas_present_o), .at_leader_o(at_leader_o),
        .ilock_err_o(ilock_err_o), .byte_o(byte_o), .byte_vld_o(byte_vld_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_mot(input string tag, input logic [2:0] exp);
        chk(tag, {5'd0, mot_fwd_o, mot_rev_o, mot_fast_o}, {5'd0, exp});
    endtask

    // bits: {stop, fast_rev, fast_fwd, play_rev, play_fwd}
    task automatic pulse(input logic [4:0] r);
        {req_stop, req_fast_rev, req_fast_fwd, req_play_rev, req_play_fwd} = r;
        @(negedge clk);
        {req_stop, req_fast_rev, req_fast_fwd, req_play_rev, req_play_fwd} = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: push expected byte, then serialize it MSB first.
    task automatic send_byte(input logic [7:0] b, input int per);
        exp_q.push_back(b);
        for (int i = 7; i >= 0; i--) begin
            rd_dat_i = b[i];
            idle(per);
            rd_clk_i = 1'b1;
            idle(per);
            rd_clk_i = 1'b0;
        end
    endtask

    // Monitor: compare each produced byte against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && byte_vld_o) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected byte", byte_o, 8'hxx);
            end else begin
                chk("R7 byte", byte_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        chk_mot("R9 reset motor", 3'b000);
        chk("R9 reset err", {7'd0, ilock_err_o}, 8'd0);
        chk("R9 reset vld", {7'd0, byte_vld_o}, 8'd0);
        chk("R9 reset byte", byte_o, 8'h00);
        rst_n = 1'b1;
        cas_sense_i = 1'b1;
        idle(4);
        chk("R8 present", {7'd0, cas_present_o}, 8'd1);

        pulse(5'b00001);
        chk_mot("R3 play fwd", 3'b100);
        pulse(5'b00100);
        chk_mot("R3 fast fwd", 3'b101);
        pulse(5'b00010);
        chk_mot("R4 gap cycle", 3'b000);
        idle(1);
        chk_mot("R4 rev after gap", 3'b010);
        pulse(5'b10000);
        chk_mot("R3 stop", 3'b000);
        pulse(5'b01000);
        chk_mot("R3 fast rev", 3'b011);

        pulse(5'b00011);
        chk_mot("R1 conflict off", 3'b000);
        chk("R2 err set", {7'd0, ilock_err_o}, 8'd1);
        idle(2);
        chk("R2 err held", {7'd0, ilock_err_o}, 8'd1);
        pulse(5'b00001);
        chk("R2 err cleared", {7'd0, ilock_err_o}, 8'd0);
        chk_mot("R2 accepted after err", 3'b100);
        pulse(5'b01001);
        chk("R2 err via fast", {7'd0, ilock_err_o}, 8'd1);
        pulse(5'b10000);
        chk("R2 err cleared by stop", {7'd0, ilock_err_o}, 8'd0);

        pulse(5'b00001);
        leader_i = 1'b1;
        idle(5);
        chk_mot("R6 stop at leader", 3'b000);
        chk("R8 at leader", {7'd0, at_leader_o}, 8'd1);
        pulse(5'b00010);
        idle(3);
        chk_mot("R6 start on leader", 3'b010);
        leader_i = 1'b0;
        idle(5);
        chk_mot("R6 runs off leader", 3'b010);
        leader_i = 1'b1;
        idle(5);
        chk_mot("R6 stop at far leader", 3'b000);
        leader_i = 1'b0;
        idle(3);

        pulse(5'b00001);
        chk_mot("R5 running", 3'b100);
        cas_sense_i = 1'b0;
        idle(5);
        chk_mot("R5 sense lost", 3'b000);
        chk("R8 absent", {7'd0, cas_present_o}, 8'd0);
        pulse(5'b00100);
        idle(2);
        chk_mot("R5 request ignored", 3'b000);
        cas_sense_i = 1'b1;
        idle(5);
        chk_mot("R5 no restart", 3'b000);

        send_byte(8'hA5, 6);
        send_byte(8'h3C, 5);
        send_byte(8'hFF, 4);
        send_byte(8'h00, 3);
        send_byte(8'h81, 2);
        idle(6);
        chk("R7 last byte held", byte_o, 8'h81);
        chk("R7 queue drained", 8'(exp_q.size()), 8'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule